// File: doc/BRIEF.md
# Divisible One-Shot / Periodic Countdown Timer

This block is a 32-bit countdown timer. A free-running base tick input is slowed down by a programmable power-of-two prescaler. Each divided tick decrements the current count. The timer runs either as a one-shot, stopping at zero, or as a periodic source that reloads itself. A small control word sets the mode, masks the output and carries an 8-bit vector. When the count expires and the control word is not masked, the block emits a one-cycle request that carries that vector.

Software loads the initial count, the divider setting and the control word through a simple write port. A combinational read port returns these values and also the live count. Routing the request into any priority logic is left to the surrounding design.

Register selects used on both ports: 0 = control word, 1 = initial count, 2 = current count, 3 = divider setting.

Top module: `tmr_top`

## Requirements
- R1: After reset the control word reads 0x0001_0000 (masked, one-shot, vector 0). The divider setting, the initial count and the current count all read 0.
- R2: A write to the divider setting keeps only bits 3, 1 and 0 (mask 0xB). The other bits read back as 0.
- R3: A 3-bit code is built as {setting[3], setting[1:0]}. The shift is (code+1) mod 8, and one divided tick happens every 2^shift base ticks. Setting 0x0 divides by 2 and setting 0xB divides by 1.
- R4: A write to the initial count loads the current count with the written value at once and restarts the prescaler from zero.
- R5: In one-shot mode (control bit 17 = 0) the current count drops by one per divided tick and holds at 0. Exactly one request is raised, on the divided tick after the count reaches 0, which is N+1 divided ticks after loading N.
- R6: In periodic mode (control bit 17 = 1), a divided tick at count 0 reloads the initial count. This gives one request every N+1 divided ticks.
- R7: An initial count of 0 never produces a request, in either mode.
- R8: When control bit 16 is set, no request is emitted, and the count keeps running.
- R9: A request is a pulse on irqValid lasting one clock cycle. irqVector carries control bits 7:0 as they stood when the request fired.
- R10: Rewriting the control word changes the mask, mode and vector without disturbing the current count.
- R11: The current count is read-only: a write to select 2 has no effect.
- R12: The control word keeps only bits 17, 16 and 7:0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Base tick enable, one cycle per tick |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write register select |
| wrData | input | 32 | Write data |
| rdSel | input | 2 | Read register select |
| rdData | output | 32 | Read data, combinational from rdSel |
| irqValid | output | 1 | One-cycle expiry request |
| irqVector | output | 8 | Vector carried by the request |

## Verification
The assertions assume that tickIn and the write port change only between clock edges. They also assume that a periodic reload can never coincide with the next expiry, which holds because a period always spans at least two divided ticks. The bench drives every input on the falling edge. It holds each base tick for exactly one cycle and keeps register writes apart from tick cycles, so a load never races a divided tick within one edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 32;
  localparam int VEC_W   = 8;
  localparam int SHIFT_W = 3;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_INIT = 2'd1;
  localparam logic [1:0] SEL_CUR  = 2'd2;
  localparam logic [1:0] SEL_DIV  = 2'd3;

  localparam int BIT_PERIODIC = 17;
  localparam int BIT_MASK     = 16;
  localparam logic [3:0] DIV_KEEP = 4'hB;

  typedef struct packed {
    logic               loadInit;
    logic               periodic;
    logic               masked;
    logic [SHIFT_W-1:0] shift;
  } tmrCtl_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  output tmrCtl_t          ctl,
  output logic [CNT_W-1:0] initCount,
  output logic [VEC_W-1:0] vector,
  output logic [3:0]       divCfg
);
  logic periodicQ;
  logic maskedQ;
  logic [SHIFT_W-1:0] code;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodicQ <= 1'b0;
      maskedQ   <= 1'b1;
      vector    <= '0;
      divCfg    <= '0;
      initCount <= '0;
    end else if (wrEn) begin
      case (wrSel)
        SEL_CTRL: begin
          periodicQ <= wrData[BIT_PERIODIC];
          maskedQ   <= wrData[BIT_MASK];
          vector    <= wrData[VEC_W-1:0];
        end
        SEL_INIT: initCount <= wrData;
        SEL_DIV:  divCfg    <= wrData[3:0] & DIV_KEEP;
        default:  ;
      endcase
    end
  end

  always_comb begin
    code         = {divCfg[3], divCfg[1:0]};
    ctl.shift    = code + SHIFT_W'(1);
    ctl.periodic = periodicQ;
    ctl.masked   = maskedQ;
    ctl.loadInit = wrEn && (wrSel == SEL_INIT);
  end
endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  tmrCtl_t          ctl,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] initCount,
  input  logic [VEC_W-1:0] vector,
  output logic [CNT_W-1:0] curCount,
  output logic             divTick,
  output logic             irqValid,
  output logic [VEC_W-1:0] irqVector
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic             done;
  logic             expire;

  always_comb begin
    preMask = ~({PRE_W{1'b1}} << ctl.shift);
    divTick = tickIn && ((preCnt & preMask) == preMask);
    expire  = divTick && (curCount == '0) && (initCount != '0)
              && (ctl.periodic || !done);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt    <= '0;
      curCount  <= '0;
      done      <= 1'b0;
      irqValid  <= 1'b0;
      irqVector <= '0;
    end else begin
      irqValid <= expire && !ctl.masked;
      if (expire && !ctl.masked) irqVector <= vector;
      if (ctl.loadInit) begin
        preCnt   <= '0;
        curCount <= loadVal;
        done     <= 1'b0;
      end else begin
        if (tickIn) preCnt <= divTick ? '0 : preCnt + PRE_W'(1);
        if (divTick) begin
          if (curCount != '0) curCount <= curCount - CNT_W'(1);
          else if (ctl.periodic) curCount <= initCount;
          else if (initCount != '0) done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickIn,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdSel,
  output logic [31:0] rdData,
  output logic        irqValid,
  output logic [7:0]  irqVector
);
  tmrCtl_t          ctl;
  logic [CNT_W-1:0] initCount;
  logic [CNT_W-1:0] curCount;
  logic [VEC_W-1:0] vector;
  logic [3:0]       divCfg;
  logic             divTick;

  tmr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .ctl(ctl), .initCount(initCount), .vector(vector), .divCfg(divCfg)
  );

  tmr_dpath dpath_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .ctl(ctl), .loadVal(wrData),
    .initCount(initCount), .vector(vector), .curCount(curCount),
    .divTick(divTick), .irqValid(irqValid), .irqVector(irqVector)
  );

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_CTRL: begin
        rdData[BIT_PERIODIC] = ctl.periodic;
        rdData[BIT_MASK]     = ctl.masked;
        rdData[VEC_W-1:0]    = vector;
      end
      SEL_INIT: rdData = initCount;
      SEL_CUR:  rdData = curCount;
      default:  rdData[3:0] = divCfg;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        irqValid,
  input logic [31:0] curCount,
  input logic [31:0] initCount,
  input logic        masked,
  input logic        loadInit,
  input logic        divTick
);
  // R9: request never lasts two cycles
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |=> !irqValid);

  // R8: a request implies the entry was unmasked when it fired
  a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> !$past(masked));

  // R7: no request from a zero initial count
  a_r7_zero_silent: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ($past(initCount) != 32'd0));

  // R5: count never exceeds the loaded value
  a_r5_cur_bounded: assert property (@(posedge clk) disable iff (!rstN)
    curCount <= initCount);

  // R4: count moves only on a load or a divided tick
  a_r4_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!loadInit && !divTick) |=> $stable(curCount));
endmodule

bind tmr_top tmr_chk chk_i (
  .clk(clk), .rstN(rstN), .irqValid(irqValid), .curCount(curCount),
  .initCount(initCount), .masked(ctl.masked), .loadInit(ctl.loadInit),
  .divTick(divTick)
);

// File: tb/tmr_top_tb_top.sv
module tmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdSel = '0;
  logic [31:0] rdData;
  logic        irqValid;
  logic [7:0]  irqVector;

  int testCount = 0;
  int failCount = 0;
  logic irqSeen;
  logic [7:0] vecSeen;

  always #4 clk = ~clk;

  tmr_top dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .irqValid(irqValid),
    .irqVector(irqVector)
  );

  // {divider setting, base ticks per divided tick}
  localparam logic [11:0] DIV_TAB [8] = '{
    {4'h0, 8'd2},  {4'h1, 8'd4},  {4'h2, 8'd8},  {4'h3, 8'd16},
    {4'h8, 8'd32}, {4'h9, 8'd64}, {4'hA, 8'd128}, {4'hB, 8'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] data);
    @(negedge clk);
    rdSel = sel;
    #1 data = rdData;
  endtask

  // one base tick; irqSeen reflects the edge that consumed it
  task automatic baseTick();
    @(negedge clk);
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
    irqSeen = irqValid;
    vecSeen = irqVector;
  endtask

  task automatic ticksToIrq(input int limit, output int n);
    n = 0;
    do begin
      baseTick();
      n++;
    end while (!irqSeen && n < limit);
  endtask

  task automatic countIrqs(input int ticks, output int n);
    n = 0;
    for (int i = 0; i < ticks; i++) begin
      baseTick();
      if (irqSeen) n++;
    end
  endtask

  initial begin
    #1600000;
    failCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 32'h0001_0000);
    rd(2'd3, v); check("R1 div", v, 32'h0);
    rd(2'd1, v); check("R1 init", v, 32'h0);
    rd(2'd2, v); check("R1 cur", v, 32'h0);
    @(negedge clk); check("R1 irq", {31'b0, irqValid}, 32'h0);

    // R3 divider table walk, one-shot load of 1 expires after 2 divided ticks
    for (int k = 0; k < 8; k++) begin
      wr(2'd3, {28'h0, DIV_TAB[k][11:8]});
      wr(2'd0, 32'h0000_0011);
      wr(2'd1, 32'd1);
      ticksToIrq(400, n);
      check($sformatf("R3 div setting %0h ticks", DIV_TAB[k][11:8]), n, 2 * DIV_TAB[k][7:0]);
    end

    // R2 divider masking
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R2 div keep", v, 32'hB);
    // R12 control word masking
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R12 ctrl keep", v, 32'h0003_00FF);

    // R4 load and restart, divide by 1
    wr(2'd0, 32'h0000_0042);
    wr(2'd1, 32'd5);
    rd(2'd2, v); check("R4 load", v, 32'd5);
    baseTick(); baseTick();
    rd(2'd2, v); check("R4 after 2", v, 32'd3);

    // R11 current count write ignored
    wr(2'd2, 32'hABC);
    rd(2'd2, v); check("R11 ro", v, 32'd3);

    // R5 one-shot, load 3 -> request on 4th tick, then silence
    wr(2'd1, 32'd3);
    ticksToIrq(50, n);
    check("R5 ticks", n, 4);
    check("R9 vector", {24'h0, vecSeen}, 32'h42);
    @(negedge clk); check("R9 pulse width", {31'b0, irqValid}, 32'h0);
    countIrqs(10, n);
    check("R5 no repeat", n, 0);
    rd(2'd2, v); check("R5 holds 0", v, 32'd0);

    // R6 periodic, load 2 -> period 3
    wr(2'd0, 32'h0002_0055);
    wr(2'd1, 32'd2);
    countIrqs(12, n);
    check("R6 irq count", n, 4);
    check("R6 vector", {24'h0, vecSeen}, 32'h55);

    // R7 periodic with zero load
    wr(2'd1, 32'd0);
    countIrqs(20, n);
    check("R7 zero", n, 0);

    // R8 masked periodic keeps counting
    wr(2'd0, 32'h0003_0055);
    wr(2'd1, 32'd2);
    baseTick();
    rd(2'd2, v); check("R8 counts", v, 32'd1);
    countIrqs(12, n);
    check("R8 masked", n, 0);

    // R10 control rewrite keeps the count
    wr(2'd0, 32'h0000_0011);
    wr(2'd1, 32'd10);
    repeat (4) baseTick();
    wr(2'd0, 32'h0000_0077);
    rd(2'd2, v); check("R10 count kept", v, 32'd6);
    ticksToIrq(50, n);
    check("R10 ticks", n, 7);
    check("R10 vector", {24'h0, vecSeen}, 32'h77);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule